// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This block does signed add and subtract on two's-complement words that are 32 bits wide by default. It has three operations: add, subtract, and reverse subtract, which swaps the minuend and the subtrahend. When a result would go past the signed range, it is pinned to the largest or the smallest representable value instead of wrapping. The arithmetic path is purely combinational. Four condition outputs come with the result: carry/borrow, overflow, sign and zero.

A short immediate can take the place of the first operand. It is sign-extended to the full word width first. One state bit, the saturation indicator, records that at least one issued operation was clamped. It stays set across any number of later, clean operations and is cleared only through a dedicated clear input. The overflow output, in contrast, describes only the operation now on the inputs.

Top module: `sat_arith_unit`

## Requirements
- R1: With op_i equal to 0 (or 3), the unit adds: result_o = b_i + a_i when there is no overflow.
- R2: With op_i equal to 1, the unit subtracts the first operand from the second: result_o = b_i - a_i when there is no overflow.
- R3: With op_i equal to 2, the unit subtracts the second operand from the first: result_o = a_i - b_i when there is no overflow.
- R4: When use_imm_i is 1, the first operand is imm_i sign-extended from 5 bits (bit 4 is the sign) and a_i is ignored.
- R5: If the exact result is above the largest signed value, result_o is 0x7FFFFFFF. If it is below the smallest, result_o is 0x80000000. In both cases ov_o is 1.
- R6: A result that lands exactly on 0x7FFFFFFF or 0x80000000 without leaving the range is not clamped, and ov_o is 0.
- R7: cy_o is the unsigned carry out of an add, or the unsigned borrow of a subtraction (minuend below subtrahend). It is taken from the raw operation, not the clamped one.
- R8: s_o is bit 31 of the clamped result_o. z_o is 1 exactly when the clamped result_o is zero.
- R9: On a clock edge where valid_i is 1 and ov_o is 1, sat_o becomes 1. It stays 1 through later operations that do not overflow.
- R10: sat_o is 0 after reset. A clock edge with sat_clr_i at 1 clears it, unless the same edge also carries a valid overflowing operation, in which case it is set. Without valid_i, an overflow on the inputs leaves sat_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation is issued this cycle (may update the sticky flag) |
| op_i | input | 2 | 0/3 add, 1 subtract (b-a), 2 reverse subtract (a-b) |
| use_imm_i | input | 1 | Replace first operand with extended immediate |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| imm_i | input | 5 | Signed immediate |
| sat_clr_i | input | 1 | Synchronous clear of the sticky saturation flag |
| result_o | output | 32 | Clamped result |
| cy_o | output | 1 | Raw carry (add) or borrow (subtract) |
| ov_o | output | 1 | Current operation overflowed and was clamped |
| s_o | output | 1 | Sign of the clamped result |
| z_o | output | 1 | Clamped result is zero |
| sat_o | output | 1 | Sticky saturation indicator |

## Verification
The sticky flag is the only state in the block. A wrong value there shows up on sat_o at the first sampling point after the edge that updated it. The bench checks sat_o before every new operation, so a lost set, a missed clear or the wrong priority is reported within one cycle. Errors in the combinational path show up on the same cycle's outputs. Random operands are biased toward the signed extremes so that clamping and the boundary values just short of clamping are both exercised often.

// File: rtl/satu_pkg.sv
package satu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_RSUB = 2'd2,
        OP_ADD2 = 2'd3
    } satu_op_e;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
    } satu_flags_t;

    function automatic logic [31:0] sext_imm5(input logic [4:0] v);
        return {{27{v[4]}}, v};
    endfunction

endpackage

// File: rtl/satu_operand_sel.sv
module satu_operand_sel
    import satu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 5
) (
    input  logic [1:0]     op_i,
    input  logic           use_imm_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [W-1:0]   lhs_o,
    output logic [W-1:0]   rhs_o,
    output logic           sub_o
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] first_op;
    satu_op_e     op;

    assign op = satu_op_e'(op_i);

    always_comb begin
        if (use_imm_i) first_op = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        else           first_op = a_i;
    end

    always_comb begin
        unique case (op)
            OP_SUB: begin
                lhs_o = b_i;
                rhs_o = first_op;
                sub_o = 1'b1;
            end
            OP_RSUB: begin
                lhs_o = first_op;
                rhs_o = b_i;
                sub_o = 1'b1;
            end
            default: begin
                lhs_o = b_i;
                rhs_o = first_op;
                sub_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/satu_adder.sv
module satu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         ov_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] rhs_eff;
    logic [W:0]   wide;

    assign rhs_eff = sub_i ? ~rhs_i : rhs_i;
    assign wide    = {1'b0, lhs_i} + {1'b0, rhs_eff} + {{W{1'b0}}, sub_i};
    assign sum_o   = wide[W-1:0];
    // carry out for add; inverted carry is the borrow for subtract
    assign cy_o    = wide[W] ^ sub_i;
    // operands of the effective addition agree in sign, sum disagrees
    assign ov_o    = (lhs_i[MSB] == rhs_eff[MSB]) && (wide[MSB] != lhs_i[MSB]);
endmodule

// File: rtl/satu_clamp.sv
module satu_clamp
    import satu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]  sum_i,
    input  logic          cy_i,
    input  logic          ov_i,
    output logic [W-1:0]  result_o,
    output satu_flags_t   flags_o
);
    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (!ov_i)          result_o = sum_i;
        else if (sum_i[W-1]) result_o = POS_LIMIT;  // wrapped negative: went too high
        else                result_o = NEG_LIMIT;
    end

    always_comb begin
        flags_o.cy = cy_i;
        flags_o.ov = ov_i;
        flags_o.s  = result_o[W-1];
        flags_o.z  = (result_o == '0);
    end
endmodule

// File: rtl/satu_sticky_reg.sv
module satu_sticky_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import satu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [1:0]       op_i,
    input  logic             use_imm_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             sat_clr_i,
    output logic [W-1:0]     result_o,
    output logic             cy_o,
    output logic             ov_o,
    output logic             s_o,
    output logic             z_o,
    output logic             sat_o
);
    logic [W-1:0] lhs, rhs, raw_sum;
    logic         is_sub, raw_cy, raw_ov;
    satu_flags_t  flags;

    satu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_sel (
        .op_i(op_i), .use_imm_i(use_imm_i), .a_i(a_i), .b_i(b_i),
        .imm_i(imm_i), .lhs_o(lhs), .rhs_o(rhs), .sub_o(is_sub)
    );

    satu_adder #(.W(W)) u_add (
        .lhs_i(lhs), .rhs_i(rhs), .sub_i(is_sub),
        .sum_o(raw_sum), .cy_o(raw_cy), .ov_o(raw_ov)
    );

    satu_clamp #(.W(W)) u_clamp (
        .sum_i(raw_sum), .cy_i(raw_cy), .ov_i(raw_ov),
        .result_o(result_o), .flags_o(flags)
    );

    satu_sticky_reg u_sat (
        .clk(clk), .rst(rst), .set_i(valid_i & flags.ov),
        .clr_i(sat_clr_i), .q_o(sat_o)
    );

    assign cy_o = flags.cy;
    assign ov_o = flags.ov;
    assign s_o  = flags.s;
    assign z_o  = flags.z;
endmodule

// File: rtl/satu_checker.sv
module satu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_i,
    input logic         sat_clr_i,
    input logic         ov_o,
    input logic [W-1:0] result_o,
    input logic         sat_o
);
    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    // R5
    clamp_extreme_chk: assert property (@(posedge clk) disable iff (rst)
        ov_o |-> (result_o == POS_LIMIT || result_o == NEG_LIMIT));

    // R9
    sat_set_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ov_o) |=> sat_o);

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_o && !sat_clr_i) |=> sat_o);

    // R10
    sat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_clr_i && !(valid_i && ov_o)) |=> !sat_o);

    // R10
    sat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !sat_clr_i) |=> $stable(sat_o));
endmodule

bind sat_arith_unit satu_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .valid_i(valid_i), .sat_clr_i(sat_clr_i),
    .ov_o(ov_o), .result_o(result_o), .sat_o(sat_o)
);

// File: tb/sat_arith_unit_bench.sv
module sat_arith_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        use_imm_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  imm_i = '0;
    logic        sat_clr_i = 1'b0;
    logic [31:0] result_o;
    logic        cy_o, ov_o, s_o, z_o, sat_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_sat = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    sat_arith_unit u_sat_arith_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .use_imm_i(use_imm_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
        .sat_clr_i(sat_clr_i), .result_o(result_o), .cy_o(cy_o),
        .ov_o(ov_o), .s_o(s_o), .z_o(z_o), .sat_o(sat_o)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference: exact math in 64 bits, then clamp
    task automatic model(input logic [1:0] op, input logic imm_sel, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] imm,
                         output logic [31:0] res, output logic cy, output logic ov) ;
        logic [31:0] f, x, y;
        longint exact;
        f = imm_sel ? {{27{imm[4]}}, imm} : a;
        if (op == 2'd2) begin x = f; y = b; end
        else            begin x = b; y = f; end
        if (op == 2'd1 || op == 2'd2) begin
            exact = longint'($signed(x)) - longint'($signed(y));
            cy = (x < y);
        end else begin
            exact = longint'($signed(x)) + longint'($signed(y));
            cy = ({1'b0, x} + {1'b0, y}) >> 32 != 33'd0;
        end
        ov = 1'b1;
        if (exact > 64'sd2147483647)       res = 32'h7FFF_FFFF;
        else if (exact < -64'sd2147483648) res = 32'h8000_0000;
        else begin res = exact[31:0]; ov = 1'b0; end
    endtask

    task automatic issue(input string req, input logic v, input logic [1:0] op,
                         input logic imm_sel, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] imm, input logic clr);
        logic [31:0] er;
        logic ecy, eov;
        @(negedge clk);
        valid_i = v; op_i = op; use_imm_i = imm_sel; a_i = a; b_i = b;
        imm_i = imm; sat_clr_i = clr;
        #1;
        model(op, imm_sel, a, b, imm, er, ecy, eov);
        cmp({req, " result"}, result_o, er);
        cmp("R7 cy", {31'd0, cy_o}, {31'd0, ecy});
        cmp("R5 ov", {31'd0, ov_o}, {31'd0, eov});
        cmp("R8 s", {31'd0, s_o}, {31'd0, er[31]});
        cmp("R8 z", {31'd0, z_o}, {31'd0, er == 32'd0});
        cmp("R9 sat before edge", {31'd0, sat_o}, {31'd0, model_sat});
        if (v && eov) model_sat = 1'b1;
        else if (clr) model_sat = 1'b0;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 5)
            0: return 32'h7FFF_FFFF - ($urandom % 16);
            1: return 32'h8000_0000 + ($urandom % 16);
            2: return $urandom % 32;
            3: return 32'hFFFF_FFFF - ($urandom % 32);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #1500000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        cmp("R10 reset sat", {31'd0, sat_o}, 32'd0);

        // R1 add, overflow both ways
        issue("R1", 1, 2'd0, 0, 32'h7000_0000, 32'h7000_0000, 0, 0);
        issue("R5", 1, 2'd0, 0, 32'h9000_0000, 32'h9000_0000, 0, 0);
        // R9 sticky across clean op
        issue("R9", 1, 2'd0, 0, 32'd1, 32'd2, 0, 0);
        issue("R10 clear", 0, 2'd0, 0, 32'd1, 32'd2, 0, 1);
        issue("R9 cleared", 1, 2'd0, 0, 32'd1, 32'd2, 0, 0);
        // R6 exact limits
        issue("R6", 1, 2'd0, 0, 32'h7000_0000, 32'h0FFF_FFFF, 0, 0);
        issue("R6", 1, 2'd0, 0, 32'h9000_0000, 32'hF000_0000, 0, 0);
        // R2 subtract second - first
        issue("R2", 1, 2'd1, 0, 32'h9000_0000, 32'h7000_0000, 0, 0);
        issue("R2", 1, 2'd1, 0, 32'h7000_0000, 32'h9000_0000, 0, 0);
        issue("R2", 1, 2'd1, 0, 32'd1, 32'd2, 0, 0);
        // R3 reverse subtract first - second
        issue("R3", 1, 2'd2, 0, 32'h9000_0000, 32'h0FFF_FFFF, 0, 1);
        issue("R3", 1, 2'd2, 0, 32'd2, 32'd1, 0, 0);
        // R4 immediate: a ignored
        issue("R4", 1, 2'd0, 1, 32'hDEAD_BEEF, 32'h7FFF_FFFE, 5'd10, 0);
        issue("R4", 1, 2'd0, 1, 32'h1234_5678, 32'h8000_0001, 5'b10110, 0);
        issue("R4", 1, 2'd1, 1, 32'h0, 32'h7FFF_FFFE, 5'b11111, 0);
        // R10 set wins over clear; invalid overflow leaves sat
        issue("R10 set wins", 1, 2'd0, 0, 32'h7000_0000, 32'h7000_0000, 0, 1);
        issue("R10 clear", 0, 2'd0, 0, 32'h7000_0000, 32'h7000_0000, 0, 1);
        issue("R10 idle ov", 0, 2'd0, 0, 32'h7000_0000, 32'h7000_0000, 0, 0);
        issue("R8 zero", 1, 2'd3, 0, 32'd5, 32'hFFFF_FFFB, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            issue("random", ($urandom % 4) != 0, 2'($urandom), ($urandom % 4) == 0,
                  pick(), pick(), 5'($urandom), ($urandom % 8) == 0);
        end
        issue("final", 0, 2'd0, 0, 32'd0, 32'd0, 0, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule